// File: doc/BRIEF.md
# Tiny-Page Two-Level Table Walker

This unit turns a modified virtual address into a physical address for 1 KB (tiny) pages. It does this by reading two descriptors from translation tables held in memory. The MMU hands it an address and the base of the first-level table. The walker then reads the first-level entry and confirms that the entry points to a fine second-level table. It then reads the second-level entry and confirms that the entry describes a tiny page. It reports the physical address, the 4-bit domain taken from the first-level entry, and the access-permission, cacheable and bufferable bits taken from the second-level entry. If either entry has the wrong type, it reports a translation fault instead.

Requests arrive over a valid/ready pair. A request transfers on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the walker is idle. The requester may hold `req_valid` for as long as it likes without losing anything.

Descriptor reads leave through a second valid/ready pair. The walker keeps `mem_req_valid` and the address steady until memory raises `mem_req_ready`. The read data then returns on `mem_rsp_valid`, which has no ready signal, because the walker always takes the word while it is waiting for one. The result is not back-pressured. It appears with a one-cycle `rsp_done` pulse and stays on the result pins until the next walk completes.

Top module: `tiny_page_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `mem_req_valid` and `rsp_done` are 0. `req_ready` is 1 only while idle. From the cycle after a request is accepted up to and including the `rsp_done` cycle, `busy` is 1 and `req_ready` is 0.
- R2: The first read of a walk uses address {ttb_base (the 18-bit level-one table base, bits 31:14), vaddr[31:20], 2'b00}.
- R3: While `mem_req_valid` is 1 and `mem_req_ready` is 0, `mem_req_valid` stays 1 and `mem_req_addr` does not change.
- R4: The second read is issued only after the first word has returned and its bits [1:0] equal 2'b11 (fine table). Its address is {d1[31:12], vaddr[19:10], 2'b00}, where d1 is the first word.
- R5: On success, `rsp_pa` = {d2[31:10], vaddr[9:0]}, `rsp_ap` = d2[5:4], `rsp_c` = d2[3], `rsp_b` = d2[2] and `rsp_domain` = d1[8:5], where d2 is the second word.
- R6: If d1[1:0] is not 2'b11, the walk ends after one read with `rsp_fault`=1 and `rsp_fault_l2`=0, and no second read is issued.
- R7: If d2[1:0] is not 2'b11, the walk ends with `rsp_fault`=1 and `rsp_fault_l2`=1. On any fault, `rsp_pa`, `rsp_domain`, `rsp_ap`, `rsp_c` and `rsp_b` read 0.
- R8: `rsp_done` is 1 for exactly one cycle per accepted request. That cycle is the one after the last read data is taken. The result pins then hold their values until the next `rsp_done`.
- R9: A `mem_rsp_valid` pulse arriving while the walker is not waiting for read data is ignored. It causes no `rsp_done`, no read request and no change to any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Modified virtual address |
| ttb_base | input | 18 | Level-one table base, address bits 31:14 |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address of the descriptor |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Descriptor word |
| busy | output | 1 | Walk in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_l2 | output | 1 | Fault came from the second level (0: first level) |
| rsp_pa | output | 32 | Physical address |
| rsp_domain | output | 4 | Domain from level-one entry |
| rsp_ap | output | 2 | Access permission bits |
| rsp_c | output | 1 | Cacheable bit |
| rsp_b | output | 1 | Bufferable bit |

## Verification
The walk is driven with random addresses, table bases and descriptor words, plus directed all-zero and all-one addresses and bases. Because the values vary, any swapped or shifted bit slice in the two read addresses or in the physical address shows up as a wrong value. Descriptor types are mostly fine/tiny, with each of the three other codes forced at each level. This separates a walk that faults at the first level from one that faults at the second, and shows a second read being issued when it should not. Random delays before `mem_req_ready` and before read data test address hold and the one-cycle done timing. Stray data pulses in idle and in the request phase confirm that unexpected read data is ignored.

// File: rtl/tpw_pkg.sv
package tpw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_DONE    = 3'd5
  } walk_state_t;

  localparam logic [1:0] KIND_FINE_TABLE = 2'b11;
  localparam logic [1:0] KIND_TINY_PAGE  = 2'b11;
endpackage

// File: rtl/tpw_addr_gen.sv
module tpw_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 10,
  parameter int PAGE_W   = 10
) (
  input  logic [ADDR_W-L1_IDX_W-3:0] ttb,
  input  logic [ADDR_W-1:0]          vaddr,
  input  logic [ADDR_W-1:0]          l1_word,
  input  logic                       use_l2,
  output logic [ADDR_W-1:0]          addr
);
  localparam int FT_W = ADDR_W - L2_IDX_W - 2;

  logic [ADDR_W-1:0] l1_addr;
  logic [ADDR_W-1:0] l2_addr;

  always_comb begin
    l1_addr = {ttb, vaddr[ADDR_W-1 -: L1_IDX_W], 2'b00};
    l2_addr = {l1_word[ADDR_W-1 -: FT_W], vaddr[PAGE_W +: L2_IDX_W], 2'b00};
    addr    = use_l2 ? l2_addr : l1_addr;
  end
endmodule

// File: rtl/tpw_decode.sv
module tpw_decode
  import tpw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 10,
  parameter int DOM_LSB = 5,
  parameter int DOM_W   = 4
) (
  input  logic [ADDR_W-1:0] rsp_word,
  input  logic [ADDR_W-1:0] l1_word,
  input  logic [ADDR_W-1:0] vaddr,
  output logic              is_fine,
  output logic              is_tiny,
  output logic [ADDR_W-1:0] pa,
  output logic [DOM_W-1:0]  domain,
  output logic [1:0]        ap,
  output logic              c_bit,
  output logic              b_bit
);
  localparam int PB_W = ADDR_W - PAGE_W;

  always_comb begin
    is_fine = (rsp_word[1:0] == KIND_FINE_TABLE);
    is_tiny = (rsp_word[1:0] == KIND_TINY_PAGE);
    pa      = {rsp_word[ADDR_W-1 -: PB_W], vaddr[PAGE_W-1:0]};
    domain  = l1_word[DOM_LSB +: DOM_W];
    ap      = rsp_word[5:4];
    c_bit   = rsp_word[3];
    b_bit   = rsp_word[2];
  end
endmodule

// File: rtl/tpw_seq.sv
module tpw_seq
  import tpw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_is_fine,
  input  logic rsp_is_tiny,
  output logic req_ready,
  output logic busy,
  output logic mem_req_valid,
  output logic use_l2,
  output logic accept,
  output logic l1_load,
  output logic res_load,
  output logic fault_evt,
  output logic fault_at_l2,
  output logic done
);
  walk_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:    if (req_valid)     st_nx = ST_L1_REQ;
      ST_L1_REQ:  if (mem_req_ready) st_nx = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rsp_valid) st_nx = rsp_is_fine ? ST_L2_REQ : ST_DONE;
      ST_L2_REQ:  if (mem_req_ready) st_nx = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rsp_valid) st_nx = ST_DONE;
      ST_DONE:                       st_nx = ST_IDLE;
      default:                       st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  logic l1_rsp, l2_rsp;

  always_comb begin
    l1_rsp        = (st == ST_L1_WAIT) && mem_rsp_valid;
    l2_rsp        = (st == ST_L2_WAIT) && mem_rsp_valid;
    req_ready     = (st == ST_IDLE);
    busy          = (st != ST_IDLE);
    mem_req_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
    use_l2        = (st == ST_L2_REQ);
    accept        = (st == ST_IDLE) && req_valid;
    l1_load       = l1_rsp;
    res_load      = (l1_rsp && !rsp_is_fine) || l2_rsp;
    fault_evt     = (l1_rsp && !rsp_is_fine) || (l2_rsp && !rsp_is_tiny);
    fault_at_l2   = (st == ST_L2_WAIT);
    done          = (st == ST_DONE);
  end

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !req_ready));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && mem_rsp_valid && !req_valid) |=> (!done && !mem_req_valid));
endmodule

// File: rtl/tiny_page_walker.sv
module tiny_page_walker
  import tpw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 10,
  parameter int PAGE_W   = 10,
  parameter int DOM_W    = 4,
  parameter int DOM_LSB  = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_vaddr,
  input  logic [ADDR_W-L1_IDX_W-3:0] ttb_base,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [ADDR_W-1:0]          mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [ADDR_W-1:0]          mem_rsp_data,
  output logic                       busy,
  output logic                       rsp_done,
  output logic                       rsp_fault,
  output logic                       rsp_fault_l2,
  output logic [ADDR_W-1:0]          rsp_pa,
  output logic [DOM_W-1:0]           rsp_domain,
  output logic [1:0]                 rsp_ap,
  output logic                       rsp_c,
  output logic                       rsp_b
);
  localparam int TTB_W = ADDR_W - L1_IDX_W - 2;

  logic [ADDR_W-1:0] vaddr_q;
  logic [TTB_W-1:0]  ttb_q;
  logic [ADDR_W-1:0] l1_q;

  logic use_l2, accept, l1_load, res_load, fault_evt, fault_at_l2;
  logic rsp_is_fine, rsp_is_tiny;
  logic [ADDR_W-1:0] dec_pa;
  logic [DOM_W-1:0]  dec_domain;
  logic [1:0]        dec_ap;
  logic              dec_c, dec_b;

  tpw_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_is_fine  (rsp_is_fine),
    .rsp_is_tiny  (rsp_is_tiny),
    .req_ready    (req_ready),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .use_l2       (use_l2),
    .accept       (accept),
    .l1_load      (l1_load),
    .res_load     (res_load),
    .fault_evt    (fault_evt),
    .fault_at_l2  (fault_at_l2),
    .done         (rsp_done)
  );

  tpw_addr_gen #(
    .ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W), .PAGE_W(PAGE_W)
  ) u_addr (
    .ttb    (ttb_q),
    .vaddr  (vaddr_q),
    .l1_word(l1_q),
    .use_l2 (use_l2),
    .addr   (mem_req_addr)
  );

  tpw_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DOM_LSB(DOM_LSB), .DOM_W(DOM_W)
  ) u_dec (
    .rsp_word(mem_rsp_data),
    .l1_word (l1_q),
    .vaddr   (vaddr_q),
    .is_fine (rsp_is_fine),
    .is_tiny (rsp_is_tiny),
    .pa      (dec_pa),
    .domain  (dec_domain),
    .ap      (dec_ap),
    .c_bit   (dec_c),
    .b_bit   (dec_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      ttb_q   <= '0;
      l1_q    <= '0;
    end else begin
      if (accept) begin
        vaddr_q <= req_vaddr;
        ttb_q   <= ttb_base;
      end
      if (l1_load) l1_q <= mem_rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_fault    <= 1'b0;
      rsp_fault_l2 <= 1'b0;
      rsp_pa       <= '0;
      rsp_domain   <= '0;
      rsp_ap       <= '0;
      rsp_c        <= 1'b0;
      rsp_b        <= 1'b0;
    end else if (res_load) begin
      rsp_fault    <= fault_evt;
      rsp_fault_l2 <= fault_evt && fault_at_l2;
      if (fault_evt) begin
        rsp_pa     <= '0;
        rsp_domain <= '0;
        rsp_ap     <= '0;
        rsp_c      <= 1'b0;
        rsp_b      <= 1'b0;
      end else begin
        rsp_pa     <= dec_pa;
        rsp_domain <= dec_domain;
        rsp_ap     <= dec_ap;
        rsp_c      <= dec_c;
        rsp_b      <= dec_b;
      end
    end
  end

  logic [1:0] reads_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                             reads_q <= 2'd0;
    else if (accept)                                        reads_q <= 2'd0;
    else if (mem_req_valid && mem_req_ready && reads_q != 2'd3) reads_q <= reads_q + 2'd1;
  end

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

  // R4
  two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !(rsp_fault && !rsp_fault_l2)) |-> (reads_q == 2'd2));

  // R6
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault && !rsp_fault_l2) |-> (reads_q == 2'd1));

  // R5
  page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_fault) |-> (rsp_pa[PAGE_W-1:0] == vaddr_q[PAGE_W-1:0]));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_done && !$past(res_load)) |-> $stable(rsp_pa));
endmodule

// File: tb/sim_tiny_page_walker.sv
`timescale 1ns/1ps
module sim_tiny_page_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [17:0] ttb_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        busy, rsp_done, rsp_fault, rsp_fault_l2, rsp_c, rsp_b;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_domain;
  logic [1:0]  rsp_ap;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  tiny_page_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .ttb_base(ttb_base), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_fault_l2(rsp_fault_l2),
    .rsp_pa(rsp_pa), .rsp_domain(rsp_domain), .rsp_ap(rsp_ap),
    .rsp_c(rsp_c), .rsp_b(rsp_b)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_l1_addr(input logic [17:0] t, input logic [31:0] va);
    return {t, va[31:20], 2'b00};
  endfunction
  function automatic logic [31:0] f_l2_addr(input logic [31:0] d1, input logic [31:0] va);
    return {d1[31:12], va[19:10], 2'b00};
  endfunction
  function automatic logic [31:0] f_pa(input logic [31:0] d2, input logic [31:0] va);
    return {d2[31:10], va[9:0]};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One descriptor read: issued address checked, ready and data delayed
  task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data, input string tag);
    int hold = $urandom % 4;
    chk({tag, " read issued"}, {31'd0, mem_req_valid}, 32'd1);
    chk({tag, " read addr"}, mem_req_addr, exp_addr);
    for (int i = 0; i < hold; i++) begin
      mem_rsp_valid = ($urandom % 2) == 1;   // stray data, R9
      mem_rsp_data  = $urandom;
      tick();
      mem_rsp_valid = 1'b0;
      chk("R3 valid held", {31'd0, mem_req_valid}, 32'd1);
      chk("R3 addr held", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    tick();
    mem_req_ready = 1'b0;
    for (int i = 0; i < int'($urandom % 4); i++) tick();
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    tick();
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = $urandom;
  endtask

  task automatic walk(input logic [31:0] va, input logic [17:0] t,
                      input logic [31:0] d1, input logic [31:0] d2);
    logic l1_bad = (d1[1:0] != 2'b11);
    logic l2_bad = (d2[1:0] != 2'b11);
    logic [31:0] e_pa;
    logic [3:0]  e_dom;
    logic [1:0]  e_ap;
    logic        e_c, e_b;
    chk("R1 ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_vaddr = va;
    ttb_base  = t;
    tick();
    req_valid = 1'b0;
    req_vaddr = $urandom;
    ttb_base  = 18'($urandom);
    chk("R1 busy", {30'd0, busy, req_ready}, 32'd2);
    serve(f_l1_addr(t, va), d1, "R2");
    if (l1_bad) begin
      chk("R6 no second read", {31'd0, mem_req_valid}, 32'd0);
    end else begin
      chk("R8 no early done", {31'd0, rsp_done}, 32'd0);
      serve(f_l2_addr(d1, va), d2, "R4");
    end
    e_pa  = (l1_bad || l2_bad) ? 32'd0 : f_pa(d2, va);
    e_dom = (l1_bad || l2_bad) ? 4'd0 : d1[8:5];
    e_ap  = (l1_bad || l2_bad) ? 2'd0 : d2[5:4];
    e_c   = (l1_bad || l2_bad) ? 1'b0 : d2[3];
    e_b   = (l1_bad || l2_bad) ? 1'b0 : d2[2];
    chk("R8 done", {30'd0, rsp_done, busy}, 32'd3);
    chk("R6 R7 fault kind", {30'd0, rsp_fault, rsp_fault_l2},
        {30'd0, l1_bad | l2_bad, !l1_bad & l2_bad});
    chk("R5 R7 pa", rsp_pa, e_pa);
    chk("R5 R7 attrs", {23'd0, rsp_domain, rsp_ap, rsp_c, rsp_b},
        {23'd0, e_dom, e_ap, e_c, e_b});
    tick();
    chk("R8 done drops", {29'd0, rsp_done, busy, req_ready}, 32'd1);
    chk("R8 pa held", rsp_pa, e_pa);
  endtask

  function automatic logic [31:0] mk_desc(input logic [31:0] raw, input logic force_bad);
    logic [1:0] k = force_bad ? 2'($urandom % 3) : ((($urandom % 8) == 0) ? 2'($urandom % 3) : 2'b11);
    return {raw[31:2], k};
  endfunction

  initial begin
    void'($urandom(32'd20260611));
    repeat (3) @(negedge clk);
    chk("R1 reset", {28'd0, req_ready, busy, mem_req_valid, rsp_done}, 32'h8);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", {28'd0, req_ready, busy, mem_req_valid, rsp_done}, 32'h8);

    // Directed corners
    walk(32'h0000_0000, 18'h00000, 32'h0000_0003, 32'h0000_0003);
    walk(32'hFFFF_FFFF, 18'h3FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    walk(32'hA5A5_A5A5, 18'h15A5A, 32'h1234_5160, 32'h0);            // L1 type 00
    walk(32'h5A5A_5A5A, 18'h2A5A5, 32'h1234_5161, 32'h0);            // L1 type 01
    walk(32'h0F0F_0F0F, 18'h0F0F0, 32'h1234_51E2, 32'h0);            // L1 type 10
    walk(32'hC3C3_C3C3, 18'h13C3C, 32'h8765_41E3, 32'hDEAD_BE3C);    // L2 type 00
    walk(32'h3C3C_3C3C, 18'h03C3C, 32'h8765_41E3, 32'hDEAD_BE3D);    // L2 type 01
    walk(32'h9999_6666, 18'h26666, 32'h8765_41E3, 32'hDEAD_BE3E);    // L2 type 10
    walk(32'h1357_9BDF, 18'h1ABCD, 32'hFEDC_B1E3, 32'hCAFE_F03F);

    // R9: stray read data while idle
    for (int i = 0; i < 4; i++) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = $urandom;
      tick();
      mem_rsp_valid = 1'b0;
      chk("R9 stray idle", {29'd0, rsp_done, mem_req_valid, busy}, 32'd0);
      chk("R9 result kept", rsp_pa, f_pa(32'hCAFE_F03F, 32'h1357_9BDF));
    end

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] va = $urandom;
      logic [17:0] t  = 18'($urandom);
      logic [31:0] d1 = mk_desc($urandom, 1'b0);
      logic [31:0] d2 = mk_desc($urandom, 1'b0);
      walk(va, t, d1, d2);
      for (int g = 0; g < int'($urandom % 3); g++) tick();
    end

    summary();
  end
endmodule